// File: doc/BRIEF.md
# Triggered Hit Matching Unit

This block collects time-stamped edge hits from a group of detector channels and turns them into a framed readout stream. Each hit carries a channel number, an edge flag (leading or trailing) and a coarse timestamp. In edge mode every edge becomes its own record. In width mode a trailing edge is paired with the open leading edge on its channel, and the pair becomes one record that holds the leading time and the pulse width. An edge that cannot be paired becomes an error record.

In untriggered mode every record goes straight into the readout FIFO. In triggered mode records are kept in a circular store. Each trigger timestamp is queued. For each trigger a controller walks the whole store from the oldest slot and copies every record whose time lies inside a window. The window opens a programmable latency before the trigger and is a programmable number of ticks wide. The copied records are framed by a header and a trailer. A record that falls inside the windows of two triggers is sent once for each of them.

The controller has four states. `S_IDLE` waits. It goes to `S_HEAD` when the mode is triggered, a trigger is queued and the FIFO has at least two free slots. `S_HEAD` writes the header and always moves to `S_SCAN`. `S_SCAN` looks at one store slot per cycle and goes to `S_TRAIL` after the last slot. `S_TRAIL` writes the trailer and returns to `S_IDLE`.

Top module: `hm_matcher`

## Requirements
- R1: When `cfg_triggered` is 0, each record goes to the FIFO in arrival order with no header or trailer, and trigger pulses have no effect.
- R2: When `cfg_triggered` is 1, a trigger at time T selects the stored records with ((t − (T − cfg_latency)) mod 2^TW) < cfg_window. All timestamp arithmetic wraps at 2^TW.
- R3: A record that lies inside the windows of several queued triggers is reported in the event of each of those triggers.
- R4: Output words carry a 2-bit tag in the top bits: 00 = data, 01 = header, 10 = trailer. A header holds the event number in its low EVW bits. The first event after reset is number 0, and the number rises by one per trigger served. The data words follow the header from the oldest stored record to the newest. The trailer holds the number of data words written in its low bits.
- R5: When `cfg_tot` is 1, a trailing edge on a channel with an open leading edge gives a record of kind 10. Its time is the leading time and its width is (trailing − leading) mod 2^TW.
- R6: When `cfg_tot` is 1, a trailing edge with no open leading edge gives a record of kind 11 carrying the trailing time. A leading edge that replaces an open one gives a kind 11 record carrying the older leading time.
- R7: During a scan, a stored record that is older than the window start and outside the window is removed. A later trigger whose window covers its time does not report it.
- R8: A data word is written only while the FIFO has at least two free slots. A matched record that is dropped for lack of space sets the overflow bit (bit OW−3) in that event's trailer, and the matcher does not stall.
- R9: The store keeps the most recent DEPTH records. A new record overwrites the oldest one.
- R10: After reset, `out_valid` is 0.
- R11: When `cfg_tot` is 0, a data word has kind 00 for a leading edge or 01 for a trailing edge, and its width is 0. The data layout below the tag is {kind[1:0], channel, time, width}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_triggered | input | 1 | 1 = trigger matching, 0 = pass every record through |
| cfg_tot | input | 1 | 1 = pair edges into width records |
| cfg_latency | input | TW | Window start offset before the trigger time |
| cfg_window | input | TW | Window width in ticks |
| hit_valid | input | 1 | Hit strobe |
| hit_chan | input | clog2(NCH) | Hit channel |
| hit_trailing | input | 1 | 1 = trailing edge |
| hit_time | input | TW | Hit timestamp |
| trig_valid | input | 1 | Trigger strobe |
| trig_time | input | TW | Trigger timestamp |
| out_valid | output | 1 | FIFO word available |
| out_ready | input | 1 | Reader takes the word |
| out_word | output | OW | Tagged output word |

## Verification
The assertions check on every cycle the rules that hold at each step. The FIFO is never pushed when full or popped when empty. The trailer always finds a free slot. A header only follows idle, and a trailer only follows a scan. The controller never leaves idle in untriggered mode. Width records appear only while pairing is enabled. Which records an event contains can only be shown by the bench scenarios. These cover window wrap-around, overlapping triggers, removal of stale records, store wrap, FIFO overflow and the rules for pairing edges and flagging unpaired ones.

// File: rtl/hm_pkg.sv
package hm_pkg;
    typedef enum logic [1:0] {K_LEAD = 2'b00, K_TRAIL = 2'b01, K_TOT = 2'b10, K_ERR = 2'b11} kind_e;
    typedef enum logic [1:0] {TAG_DATA = 2'b00, TAG_HEAD = 2'b01, TAG_TRAIL = 2'b10} tag_e;
    typedef enum logic [1:0] {S_IDLE, S_HEAD, S_SCAN, S_TRAIL} state_e;
endpackage

// File: rtl/hm_fifo.sv
module hm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout = mem[rp];

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)) || pop); // R8
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R1
endmodule

// File: rtl/hm_pairer.sv
module hm_pairer
    import hm_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int TW   = 12,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tot_en,
    input  logic           in_vld,
    input  logic [CHW-1:0] in_chan,
    input  logic           in_trail,
    input  logic [TW-1:0]  in_time,
    output logic           rec_vld,
    output kind_e          rec_kind,
    output logic [CHW-1:0] rec_chan,
    output logic [TW-1:0]  rec_time,
    output logic [TW-1:0]  rec_width
);
    logic [NCH-1:0] open_lead;
    logic [TW-1:0]  lead_t [NCH];
    logic           pend;
    logic [TW-1:0]  pt;

    assign pend = open_lead[in_chan];
    assign pt   = lead_t[in_chan];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_lead <= '0;
            for (int c = 0; c < NCH; c++) lead_t[c] <= '0;
            rec_vld   <= 1'b0;
            rec_kind  <= K_LEAD;
            rec_chan  <= '0;
            rec_time  <= '0;
            rec_width <= '0;
        end else begin
            rec_vld <= 1'b0;
            if (in_vld) begin
                rec_chan <= in_chan;
                if (!tot_en) begin
                    rec_vld   <= 1'b1;
                    rec_kind  <= in_trail ? K_TRAIL : K_LEAD;
                    rec_time  <= in_time;
                    rec_width <= '0;
                end else if (!in_trail) begin
                    rec_vld            <= pend;
                    rec_kind           <= K_ERR;
                    rec_time           <= pt;
                    rec_width          <= '0;
                    open_lead[in_chan] <= 1'b1;
                    lead_t[in_chan]    <= in_time;
                end else begin
                    rec_vld            <= 1'b1;
                    rec_kind           <= pend ? K_TOT : K_ERR;
                    rec_time           <= pend ? pt : in_time;
                    rec_width          <= pend ? in_time - pt : '0;
                    open_lead[in_chan] <= 1'b0;
                end
            end
        end
    end

    AST_PAIR_ONLY_IN_TOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld && rec_kind == K_TOT) |-> $past(tot_en)); // R5
    AST_EDGE_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_vld && !$past(tot_en)) |-> (rec_kind == K_LEAD || rec_kind == K_TRAIL)); // R11
endmodule

// File: rtl/hm_matcher.sv
module hm_matcher
    import hm_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int TW        = 12,
    parameter int DEPTH     = 32,
    parameter int OUT_DEPTH = 16,
    parameter int TQ_DEPTH  = 4,
    parameter int EVW       = 12,
    localparam int CHW      = $clog2(NCH),
    localparam int RW       = 2 + CHW + 2 * TW,
    localparam int OW       = 2 + RW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_triggered,
    input  logic           cfg_tot,
    input  logic [TW-1:0]  cfg_latency,
    input  logic [TW-1:0]  cfg_window,
    input  logic           hit_valid,
    input  logic [CHW-1:0] hit_chan,
    input  logic           hit_trailing,
    input  logic [TW-1:0]  hit_time,
    input  logic           trig_valid,
    input  logic [TW-1:0]  trig_time,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [OW-1:0]  out_word
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CNW = $clog2(DEPTH + 1);
    localparam int OCW = $clog2(OUT_DEPTH + 1);
    localparam int TCW = $clog2(TQ_DEPTH + 1);

    // edge pairing
    logic           rec_vld;
    kind_e          rec_kind;
    logic [CHW-1:0] rec_chan;
    logic [TW-1:0]  rec_time, rec_width;
    logic [RW-1:0]  rec_word;

    hm_pairer #(.NCH(NCH), .TW(TW)) u_pair (
        .clk(clk), .rst_n(rst_n), .tot_en(cfg_tot),
        .in_vld(hit_valid), .in_chan(hit_chan), .in_trail(hit_trailing), .in_time(hit_time),
        .rec_vld(rec_vld), .rec_kind(rec_kind), .rec_chan(rec_chan),
        .rec_time(rec_time), .rec_width(rec_width));
    assign rec_word = {rec_kind, rec_chan, rec_time, rec_width};

    // trigger queue
    logic           tq_push, tq_pop;
    logic [TW-1:0]  tq_time;
    logic [TCW-1:0] tq_cnt;
    assign tq_push = trig_valid && cfg_triggered && (tq_cnt != TCW'(TQ_DEPTH));

    hm_fifo #(.W(TW), .DEPTH(TQ_DEPTH)) u_tq (
        .clk(clk), .rst_n(rst_n), .push(tq_push), .din(trig_time),
        .pop(tq_pop), .dout(tq_time), .count(tq_cnt));

    // readout fifo
    logic           f_push, f_pop, f_full, room;
    logic [OW-1:0]  f_din;
    logic [OCW-1:0] f_cnt;
    assign out_valid = (f_cnt != '0);
    assign f_pop     = out_valid && out_ready;
    assign f_full    = (f_cnt == OCW'(OUT_DEPTH));
    assign room      = (f_cnt <= OCW'(OUT_DEPTH - 2));

    hm_fifo #(.W(OW), .DEPTH(OUT_DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n), .push(f_push), .din(f_din),
        .pop(f_pop), .dout(out_word), .count(f_cnt));

    // circular store and scan state
    logic [RW-1:0]  store_rec [DEPTH];
    logic [DEPTH-1:0] store_vld;
    logic [AW-1:0]  wr_ptr, scan_idx, scan_n;
    logic [TW-1:0]  win_start;
    logic [CNW-1:0] word_cnt;
    logic [EVW-1:0] evt_cnt;
    logic           ovf;
    state_e         state, next_state;

    logic [RW-1:0] cur;
    logic [TW-1:0] cur_time, rel, age;
    logic          in_win, stale, start;

    assign cur      = store_rec[scan_idx];
    assign cur_time = cur[2*TW-1:TW];
    assign rel      = cur_time - win_start;
    assign age      = win_start - cur_time;
    assign in_win   = store_vld[scan_idx] && (rel < cfg_window);
    assign stale    = store_vld[scan_idx] && !in_win && (age != '0) && !age[TW-1];
    assign start    = cfg_triggered && (tq_cnt != '0) && room;
    assign tq_pop   = (state == S_IDLE) && start;

    always_ff @(posedge clk) begin
        if (cfg_triggered && rec_vld) store_rec[wr_ptr] <= rec_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_vld <= '0;
            wr_ptr    <= '0;
        end else begin
            if (state == S_SCAN && stale) store_vld[scan_idx] <= 1'b0;
            if (cfg_triggered && rec_vld) begin
                store_vld[wr_ptr] <= 1'b1;
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:  if (start) next_state = S_HEAD;
            S_HEAD:  next_state = S_SCAN;
            S_SCAN:  if (scan_n == AW'(DEPTH - 1)) next_state = S_TRAIL;
            S_TRAIL: next_state = S_IDLE;
        endcase
    end

    // event datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_start <= '0;
            scan_idx  <= '0;
            scan_n    <= '0;
            word_cnt  <= '0;
            evt_cnt   <= '0;
            ovf       <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) win_start <= tq_time - cfg_latency;
                S_HEAD: begin
                    scan_idx <= wr_ptr;
                    scan_n   <= '0;
                    word_cnt <= '0;
                    ovf      <= 1'b0;
                end
                S_SCAN: begin
                    scan_idx <= (scan_idx == AW'(DEPTH - 1)) ? '0 : scan_idx + 1'b1;
                    scan_n   <= scan_n + 1'b1;
                    if (in_win && room)  word_cnt <= word_cnt + 1'b1;
                    if (in_win && !room) ovf <= 1'b1;
                end
                S_TRAIL: evt_cnt <= evt_cnt + 1'b1;
            endcase
        end
    end

    // fifo writes
    always_comb begin
        f_push = 1'b0;
        f_din  = '0;
        unique case (state)
            S_IDLE: if (!cfg_triggered && rec_vld && !f_full) begin
                f_push = 1'b1;
                f_din  = {TAG_DATA, rec_word};
            end
            S_HEAD: begin
                f_push = 1'b1;
                f_din  = OW'(evt_cnt);
                f_din[OW-1 -: 2] = TAG_HEAD;
            end
            S_SCAN: if (in_win && room) begin
                f_push = 1'b1;
                f_din  = {TAG_DATA, cur};
            end
            S_TRAIL: begin
                f_push = 1'b1;
                f_din  = OW'(word_cnt);
                f_din[OW-3] = ovf;
                f_din[OW-1 -: 2] = TAG_TRAIL;
            end
        endcase
    end

    AST_TRAILER_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRAIL) |-> !f_full); // R8
    AST_HEADER_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HEAD) |-> ($past(state) == S_IDLE)); // R4
    AST_TRAILER_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRAIL) |-> ($past(state) == S_SCAN)); // R4
    AST_IDLE_UNTRIGGERED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !cfg_triggered) |=> (state == S_IDLE)); // R1
endmodule

// File: tb/hm_matcher_tb.sv
module hm_matcher_tb;
    localparam int NCH = 8, TW = 12, DEPTH = 32, OD = 16, EVW = 12;
    localparam int CHW = $clog2(NCH);
    localparam int OW  = 4 + CHW + 2 * TW;
    localparam int MASK = (1 << TW) - 1;

    logic clk = 0, rst_n = 0;
    logic cfg_triggered = 0, cfg_tot = 0;
    logic [TW-1:0] cfg_latency = TW'(100), cfg_window = TW'(20);
    logic hit_valid = 0, hit_trailing = 0, trig_valid = 0, out_ready = 1;
    logic [CHW-1:0] hit_chan = '0;
    logic [TW-1:0] hit_time = '0, trig_time = '0;
    logic out_valid;
    logic [OW-1:0] out_word;

    hm_matcher #(.NCH(NCH), .TW(TW), .DEPTH(DEPTH), .OUT_DEPTH(OD), .EVW(EVW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_triggered(cfg_triggered), .cfg_tot(cfg_tot),
        .cfg_latency(cfg_latency), .cfg_window(cfg_window),
        .hit_valid(hit_valid), .hit_chan(hit_chan), .hit_trailing(hit_trailing), .hit_time(hit_time),
        .trig_valid(trig_valid), .trig_time(trig_time),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word));

    always #2.5 clk = ~clk;

    typedef struct { int kind; int ch; int t; int w; bit v; } rec_t;
    rec_t store[$];
    logic [OW-1:0] expq[$];
    bit   open_lead [NCH];
    int   lead_t [NCH];
    int   evt = 0, total = 0, bad = 0;
    bit   hold = 0, done = 0;
    string cur_req = "R10";

    function automatic logic [OW-1:0] data_w(int kind, int ch, int t, int w);
        return {2'b00, 2'(kind), CHW'(ch), TW'(t & MASK), TW'(w & MASK)};
    endfunction

    task automatic check(bit ok, logic [OW-1:0] act, logic [OW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", cur_req, act, exp);
        end
    endtask

    // model: record from one hit
    task automatic model_hit(int ch, bit tr, int t);
        rec_t r; bit emit = 1;
        r.ch = ch; r.v = 1; r.w = 0; r.t = t;
        if (!cfg_tot) r.kind = tr ? 1 : 0;
        else if (!tr) begin
            emit = open_lead[ch]; r.kind = 3; r.t = lead_t[ch];
            open_lead[ch] = 1; lead_t[ch] = t;
        end else if (open_lead[ch]) begin
            r.kind = 2; r.t = lead_t[ch]; r.w = (t - lead_t[ch]) & MASK; open_lead[ch] = 0;
        end else r.kind = 3;
        if (emit) begin
            if (cfg_triggered) begin
                store.push_back(r);
                if (store.size() > DEPTH) void'(store.pop_front());
            end else expq.push_back(data_w(r.kind, r.ch, r.t, r.w));
        end
    endtask

    task automatic model_trig(int t);
        int ws = (t - int'(cfg_latency)) & MASK;
        int cnt = 0; bit of = 0;
        logic [OW-1:0] w;
        w = OW'(evt & ((1 << EVW) - 1)); w[OW-1 -: 2] = 2'b01;
        expq.push_back(w);
        evt++;
        foreach (store[i]) begin
            int rel = (store[i].t - ws) & MASK;
            int age = (ws - store[i].t) & MASK;
            if (!store[i].v) continue;
            if (rel < int'(cfg_window)) begin
                int free = hold ? OD - expq.size() : OD;
                if (free >= 2) begin
                    expq.push_back(data_w(store[i].kind, store[i].ch, store[i].t, store[i].w));
                    cnt++;
                end else of = 1;
            end else if (age != 0 && age < (1 << (TW - 1))) store[i].v = 0;
        end
        w = OW'(cnt); w[OW-3] = of; w[OW-1 -: 2] = 2'b10;
        expq.push_back(w);
    endtask

    task automatic send_hit(int ch, bit tr, int t);
        hit_chan = CHW'(ch); hit_trailing = tr; hit_time = TW'(t & MASK); hit_valid = 1;
        model_hit(ch, tr, t & MASK);
        @(posedge clk); #1;
        hit_valid = 0;
    endtask

    task automatic send_trig(int t);
        trig_time = TW'(t & MASK); trig_valid = 1;
        if (cfg_triggered) model_trig(t & MASK);
        @(posedge clk); #1;
        trig_valid = 0;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_drained();
        total++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL %s: actual %0d words pending expected 0", cur_req, expq.size());
        end
    endtask

    // every-clock comparison of the output stream
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() == 0) check(1'b0, out_word, '0);
            else begin
                logic [OW-1:0] e;
                e = expq.pop_front();
                check(out_word === e, out_word, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin open_lead[c] = 0; lead_t[c] = 0; end
        settle(3);
        // R10: reset state
        cur_req = "R10";
        @(negedge clk);
        check(out_valid == 1'b0, OW'(out_valid), '0);
        rst_n = 1;
        settle(2);

        // R1 and R11: pass-through, triggers ignored, edge kinds
        cur_req = "R1";
        send_hit(1, 0, 10);
        send_hit(2, 1, 15);
        send_trig(300);
        send_hit(7, 0, 4095);
        settle(20);
        check_drained();
        cur_req = "R11";
        send_hit(0, 1, 77);
        settle(10);
        check_drained();

        // R5 and R6: pairing in pass-through mode
        cfg_tot = 1;
        cur_req = "R5";
        send_hit(3, 0, 200);
        send_hit(3, 1, 230);
        send_hit(6, 0, 4090);
        send_hit(6, 1, 5);
        settle(10);
        check_drained();
        cur_req = "R6";
        send_hit(4, 1, 50);
        send_hit(5, 0, 300);
        send_hit(5, 0, 310);
        send_hit(5, 1, 320);
        settle(10);
        check_drained();
        cfg_tot = 0;

        // R2 and R4: triggered window
        cfg_triggered = 1;
        settle(2);
        cur_req = "R2";
        send_hit(0, 0, 495);
        send_hit(1, 0, 500);
        send_hit(2, 1, 510);
        send_hit(3, 0, 519);
        send_hit(4, 0, 520);
        settle(3);
        send_trig(600);
        settle(60);
        check_drained();

        // R7: stale record 495 removed by previous scan
        cur_req = "R7";
        cfg_latency = TW'(110);
        send_trig(605);
        settle(60);
        check_drained();
        cfg_latency = TW'(100);

        // R3: overlapping triggers share record 1510
        cur_req = "R3";
        send_hit(1, 0, 1500);
        send_hit(2, 0, 1510);
        send_hit(3, 0, 1525);
        settle(3);
        send_trig(1600);
        send_trig(1610);
        settle(120);
        check_drained();

        // R2: window across timestamp wrap
        cur_req = "R2";
        send_hit(0, 0, 4090);
        send_hit(1, 1, 4095);
        send_hit(2, 0, 3);
        send_hit(3, 0, 30);
        settle(3);
        send_trig(92);
        settle(60);
        check_drained();

        // R5: width record selected by trigger
        cur_req = "R5";
        cfg_tot = 1;
        send_hit(1, 0, 2500);
        send_hit(1, 1, 2507);
        settle(3);
        send_trig(2600);
        settle(60);
        check_drained();
        cfg_tot = 0;

        // R9: store keeps newest DEPTH records
        cur_req = "R9";
        cfg_window = TW'(64);
        for (int i = 0; i < DEPTH + 8; i++) send_hit(i % NCH, 0, 3000 + i);
        settle(3);
        send_trig(3100);
        settle(60);
        check_drained();

        // R8: overflow with reader stalled
        cur_req = "R8";
        hold = 1; out_ready = 0;
        send_trig(3101);
        settle(60);
        out_ready = 1;
        settle(40);
        hold = 0;
        check_drained();

        // R4: event numbering continues after overflow
        cur_req = "R4";
        cfg_window = TW'(20);
        send_trig(3150);
        settle(60);
        check_drained();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule